// File: doc/BRIEF.md
# Base and Bound Address Relocator

This block turns logical addresses into physical addresses for two independent request streams: instruction fetch and data access (loads and stores). Each stream has its own pair of configuration registers, a base and a bound. For every request the block adds the logical address to the stream's base and compares the logical address against the stream's bound, which holds the segment length. A request whose logical address lies outside the segment is not issued: its physical-address valid output stays low and a violation flag is raised instead.

The translate path is purely combinational, so a request is answered in the same cycle it is presented. The four registers are clocked and sit behind a small register port. That port is usable only while the supervisor-mode input is high. In user mode a write is dropped and a one-cycle privilege-error pulse is produced, and reads return zero. Several program contexts may share one code segment by loading the same program base.

The block has no sequencing state machine. Its only states are the contents of the four registers, which take a new value one clock edge after a supervisor write, and the privilege-error flag, which lasts one cycle.

Top module: `bbr_relocator`

## Requirements
- R1: After reset all four registers read as zero (in supervisor mode) and `priv_err` is low.
- R2: An instruction request with `if_laddr < prog_bound` gives `if_valid`=1, `if_viol`=0 and `if_paddr` = (`if_laddr` + program base) mod 2^AW in the same cycle.
- R3: A data request uses only the data base and data bound, with the same rule as R2 on the `dm_*` ports. It is unaffected by the program pair, and both streams are answered in the same cycle.
- R4: A request with logical address >= its bound gives valid=0, viol=1 and paddr=0. When a stream has no request, its valid, viol and paddr are all 0.
- R5: A bound of zero blocks every request on that stream, including logical address 0.
- R6: With `sup_mode`=1 and `cfg_we`=1, the register picked by `cfg_sel` (0 program base, 1 program bound, 2 data base, 3 data bound) takes `cfg_wdata` at the clock edge. The new value is seen by `cfg_rdata` and by translation from the next cycle on.
- R7: A write with `sup_mode`=0 changes no register. `priv_err` is high in the cycle after the attempt, and only then.
- R8: `cfg_rdata` returns the register picked by `cfg_sel` while `sup_mode`=1, and returns zero while `sup_mode`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_mode | input | 1 | Processor is in supervisor mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 program base, 1 program bound, 2 data base, 3 data bound |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Selected register value, zero in user mode |
| priv_err | output | 1 | One-cycle pulse after a user-mode write attempt |
| if_req | input | 1 | Instruction fetch request |
| if_laddr | input | AW | Instruction logical address |
| if_paddr | output | AW | Instruction physical address |
| if_valid | output | 1 | Instruction physical address is valid |
| if_viol | output | 1 | Instruction bounds violation |
| dm_req | input | 1 | Data access request |
| dm_laddr | input | AW | Data logical address |
| dm_paddr | output | AW | Data physical address |
| dm_valid | output | 1 | Data physical address is valid |
| dm_viol | output | 1 | Data bounds violation |

## Verification
A wrong register value shows up right away, in the next request on the stream that owns it. A base error offsets the physical address, and a bound error moves the edge between valid and violating addresses. The bench probes both sides of that edge directly, at bound-1 and at bound. A user write that leaks into a register, or a write that lands in the wrong register, is visible through `cfg_rdata` and through translation in the very next cycle. A privilege-error pulse that is missing or lasts too long differs from the bench's model on the cycle right after the write attempt.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
    typedef enum logic [1:0] {
        SEL_PROG_BASE  = 2'd0,
        SEL_PROG_BOUND = 2'd1,
        SEL_DATA_BASE  = 2'd2,
        SEL_DATA_BOUND = 2'd3
    } cfg_sel_e;

    localparam int NUM_STREAMS = 2;
    localparam int STREAM_IF   = 0;
    localparam int STREAM_DM   = 1;
endpackage

// File: rtl/bbr_cfg_regs.sv
module bbr_cfg_regs
    import bbr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sup_mode,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    output logic          priv_err,
    output logic [AW-1:0] prog_base,
    output logic [AW-1:0] prog_bound,
    output logic [AW-1:0] data_base,
    output logic [AW-1:0] data_bound
);
    cfg_sel_e sel;
    logic     wr_ok;
    logic     wr_bad;

    assign sel    = cfg_sel_e'(cfg_sel);
    assign wr_ok  = cfg_we && sup_mode;
    assign wr_bad = cfg_we && !sup_mode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_base  <= '0;
            prog_bound <= '0;
            data_base  <= '0;
            data_bound <= '0;
            priv_err   <= 1'b0;
        end else begin
            priv_err <= wr_bad;
            if (wr_ok) begin
                unique case (sel)
                    SEL_PROG_BASE:  prog_base  <= cfg_wdata;
                    SEL_PROG_BOUND: prog_bound <= cfg_wdata;
                    SEL_DATA_BASE:  data_base  <= cfg_wdata;
                    SEL_DATA_BOUND: data_bound <= cfg_wdata;
                endcase
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (sup_mode) begin
            unique case (sel)
                SEL_PROG_BASE:  cfg_rdata = prog_base;
                SEL_PROG_BOUND: cfg_rdata = prog_bound;
                SEL_DATA_BASE:  cfg_rdata = data_base;
                SEL_DATA_BOUND: cfg_rdata = data_bound;
            endcase
        end
    end

    // R7: a user-mode attempt leaves every register untouched
    assert_user_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |=> ($stable(prog_base) && $stable(prog_bound) &&
                    $stable(data_base) && $stable(data_bound)));

    // R7: the error flag follows the attempt by one cycle
    assert_priv_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |=> priv_err);

    // R6: a supervisor write to the program bound lands there
    assert_sup_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && cfg_sel == 2'd1) |=> (prog_bound == $past(cfg_wdata)));

    // R8: nothing leaks out of the read port in user mode
    assert_user_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_mode |-> (cfg_rdata == '0));
endmodule

// File: rtl/bbr_xlate.sv
module bbr_xlate #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] laddr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] bound,
    output logic [AW-1:0] paddr,
    output logic          valid,
    output logic          viol
);
    logic          in_seg;
    logic [AW-1:0] sum;

    assign in_seg = laddr < bound;
    assign sum    = laddr + base;

    always_comb begin
        valid = req && in_seg;
        viol  = req && !in_seg;
        paddr = valid ? sum : '0;
    end

    // R4: never valid and violating at once
    assert_valid_viol_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && viol));

    // R4: idle stream shows nothing
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (!valid && !viol && paddr == '0));

    // R5: a zero-length segment admits nothing
    assert_bound_zero_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && bound == '0) |-> (viol && !valid));
endmodule

// File: rtl/bbr_relocator.sv
module bbr_relocator
    import bbr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sup_mode,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    output logic          priv_err,
    input  logic          if_req,
    input  logic [AW-1:0] if_laddr,
    output logic [AW-1:0] if_paddr,
    output logic          if_valid,
    output logic          if_viol,
    input  logic          dm_req,
    input  logic [AW-1:0] dm_laddr,
    output logic [AW-1:0] dm_paddr,
    output logic          dm_valid,
    output logic          dm_viol
);
    logic [AW-1:0] prog_base, prog_bound, data_base, data_bound;

    logic [NUM_STREAMS-1:0]         s_req, s_valid, s_viol;
    logic [NUM_STREAMS-1:0][AW-1:0] s_laddr, s_base, s_bound, s_paddr;

    bbr_cfg_regs #(.AW(AW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .sup_mode   (sup_mode),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .priv_err   (priv_err),
        .prog_base  (prog_base),
        .prog_bound (prog_bound),
        .data_base  (data_base),
        .data_bound (data_bound)
    );

    assign s_req[STREAM_IF]   = if_req;
    assign s_laddr[STREAM_IF] = if_laddr;
    assign s_base[STREAM_IF]  = prog_base;
    assign s_bound[STREAM_IF] = prog_bound;
    assign s_req[STREAM_DM]   = dm_req;
    assign s_laddr[STREAM_DM] = dm_laddr;
    assign s_base[STREAM_DM]  = data_base;
    assign s_bound[STREAM_DM] = data_bound;

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
        bbr_xlate #(.AW(AW)) u_xlate (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (s_req[g]),
            .laddr (s_laddr[g]),
            .base  (s_base[g]),
            .bound (s_bound[g]),
            .paddr (s_paddr[g]),
            .valid (s_valid[g]),
            .viol  (s_viol[g])
        );
    end

    assign if_paddr = s_paddr[STREAM_IF];
    assign if_valid = s_valid[STREAM_IF];
    assign if_viol  = s_viol[STREAM_IF];
    assign dm_paddr = s_paddr[STREAM_DM];
    assign dm_valid = s_valid[STREAM_DM];
    assign dm_viol  = s_viol[STREAM_DM];
endmodule

// File: tb/tb_bbr_relocator.sv
module tb_bbr_relocator;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sup_mode = 1'b0, cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0, cfg_rdata;
    logic          priv_err;
    logic          if_req = 1'b0, dm_req = 1'b0;
    logic [AW-1:0] if_laddr = '0, dm_laddr = '0, if_paddr, dm_paddr;
    logic          if_valid, if_viol, dm_valid, dm_viol;

    int checks = 0;
    int failures = 0;
    logic [AW-1:0] m_reg [4];
    logic          m_perr = 1'b0;

    always #4 clk = ~clk;

    bbr_relocator #(.AW(AW)) dut (.*);

    task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW+1:0] expect_x(logic r, logic [AW-1:0] la,
                                               logic [AW-1:0] b, logic [AW-1:0] bd);
        logic ok;
        ok = r && (la < bd);
        return {ok, r && !ok, ok ? la + b : {AW{1'b0}}};
    endfunction

    // Inputs already applied: check outputs, then advance model over the edge
    task automatic step(string tag);
        logic [AW+1:0] ei, ed;
        #1;
        ei = expect_x(if_req, if_laddr, m_reg[0], m_reg[1]);
        ed = expect_x(dm_req, dm_laddr, m_reg[2], m_reg[3]);
        chk({tag, " R2 if_paddr"}, if_paddr, ei[AW-1:0]);
        chk({tag, " R4 if_valid"}, AW'(if_valid), AW'(ei[AW+1]));
        chk({tag, " R4 if_viol"},  AW'(if_viol),  AW'(ei[AW]));
        chk({tag, " R3 dm_paddr"}, dm_paddr, ed[AW-1:0]);
        chk({tag, " R3 dm_valid"}, AW'(dm_valid), AW'(ed[AW+1]));
        chk({tag, " R3 dm_viol"},  AW'(dm_viol),  AW'(ed[AW]));
        chk({tag, " R8 rdata"}, cfg_rdata, sup_mode ? m_reg[cfg_sel] : '0);
        chk({tag, " R7 priv_err"}, AW'(priv_err), AW'(m_perr));
        m_perr = cfg_we && !sup_mode;
        if (cfg_we && sup_mode) m_reg[cfg_sel] = cfg_wdata;
        @(negedge clk);
    endtask

    task automatic drive(logic s, logic we, logic [1:0] sel, logic [AW-1:0] wd,
                         logic ir, logic [AW-1:0] ia, logic dr, logic [AW-1:0] da);
        sup_mode = s; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        if_req = ir; if_laddr = ia; dm_req = dr; dm_laddr = da;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, read each register
        for (int i = 0; i < 4; i++) begin
            drive(1, 0, 2'(i), 0, 0, 0, 0, 0);
            #1; chk("R1 reset reg", cfg_rdata, '0);
            chk("R1 reset priv_err", AW'(priv_err), '0);
            step("R1");
        end
        // R5: zero bound blocks address 0 on both streams
        drive(1, 0, 0, 0, 1, 0, 1, 0);
        #1; chk("R5 if_viol bound0", AW'(if_viol), 1);
        chk("R5 dm_viol bound0", AW'(dm_viol), 1);
        step("R5");
        // R6: program writes
        drive(1, 1, 0, 32'hFFFF_FF00, 0, 0, 0, 0); step("R6");
        drive(1, 1, 1, 32'h0000_0400, 0, 0, 0, 0); step("R6");
        drive(1, 1, 2, 32'h0010_0000, 0, 0, 0, 0); step("R6");
        drive(1, 1, 3, 32'h0000_0010, 1, 32'h3FF, 0, 0); step("R6");
        // R2 boundary and wraparound: bound-1 valid, bound violates
        drive(1, 0, 1, 0, 1, 32'h3FF, 1, 32'hF);
        #1; chk("R2 wrap paddr", if_paddr, 32'h0000_02FF);
        chk("R3 dm edge paddr", dm_paddr, 32'h0010_000F);
        step("R2");
        drive(1, 0, 3, 0, 1, 32'h400, 1, 32'h10);
        #1; chk("R4 if at bound", AW'(if_viol), 1);
        chk("R4 dm at bound", AW'(dm_viol), 1);
        step("R4");
        // R7: user write ignored, pulse next cycle only
        drive(0, 1, 1, 32'hDEAD, 1, 32'h3FF, 0, 0); step("R7");
        drive(1, 0, 1, 0, 1, 32'h3FF, 0, 0);
        #1; chk("R7 pulse", AW'(priv_err), 1);
        chk("R7 bound kept", cfg_rdata, 32'h400);
        step("R7");
        drive(1, 0, 1, 0, 0, 0, 0, 0);
        #1; chk("R7 pulse ends", AW'(priv_err), 0);
        step("R7");
        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] ia, da;
            ia = (($urandom % 3) == 0) ? m_reg[1] - AW'($urandom % 2) : AW'($urandom % 32'h800);
            da = (($urandom % 3) == 0) ? m_reg[3] - AW'($urandom % 2) : AW'($urandom % 32'h40);
            drive(($urandom % 4) != 0, ($urandom % 5) == 0, 2'($urandom),
                  (($urandom % 2) == 0) ? AW'($urandom % 32'h800) : AW'($urandom),
                  ($urandom % 4) != 0, ia, ($urandom % 4) != 0, da);
            step("RND");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule